// File: doc/BRIEF.md
# Real-Time Bit Error Rate Checker

This block sits on the receive side of a packet PHY, between the demodulated byte stream and the packet buffer. In normal operation it forwards each received byte to the buffer write port. When BER mode is selected, no byte is written. Each received byte is compared instead with a golden byte read from the same buffer address. The block keeps two software-readable counters: the number of bit errors found and the number of bits examined.

The byte address and the write strobe reach the block two cycles before the matching data byte. Both are retimed by two registers so that all three line up. In BER mode the aligned strobe and address start a golden-buffer read with one cycle of latency. The received byte is held for one cycle to meet the returning golden byte. The counters are updated on the edge that closes that compare cycle. Results are only meaningful if the transmitted packet was loaded into the buffer, starting at byte address 0, before transmission began.

Top module: `ber_rt_checker`

## Requirements
- R1: While `ber_mode_i` is 1, `buf_wr_en_o` is 0 in every cycle.
- R2: While `ber_mode_i` is 0, `buf_wr_en_o` equals `rx_we_i` from two cycles earlier. When it is 1, `buf_wr_addr_o` equals `rx_addr_i` from two cycles earlier and `buf_wr_data_o` equals `rx_byte_i` of the current cycle.
- R3: While `ber_mode_i` is 1, `gold_rd_en_o` equals `rx_we_i` from two cycles earlier. When it is 1, `gold_rd_addr_o` equals `rx_addr_i` from two cycles earlier. While `ber_mode_i` is 0, `gold_rd_en_o` is 0.
- R4: A byte is aligned in cycle c when `gold_rd_en_o` is 1 in cycle c. `gold_rd_data_i` in cycle c+1 carries the buffer byte at that address. From cycle c+2, `err_bits_o` has grown by the number of 1 bits in (`rx_byte_i` of cycle c XOR that golden byte).
- R5: Each byte aligned in BER mode adds 8 to `tot_bits_o`, visible from two cycles after the aligned cycle.
- R6: When no byte was aligned in BER mode in the cycle before, both counters keep their values, unless cleared. In particular, a byte aligned in normal mode never changes either counter.
- R7: Each counter saturates at all ones. An increment that would pass the maximum leaves the counter at the maximum.
- R8: A one-cycle pulse on `clear_i` sets both counters to 0 in the next cycle. The clear has priority over any increment due on the same edge, and that increment is discarded.
- R9: After reset both counters are 0, and `buf_wr_en_o` and `gold_rd_en_o` stay 0 until a strobe has passed through the two-cycle retiming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ber_mode_i | input | 1 | 1 selects BER checking; 0 selects normal buffer writes |
| clear_i | input | 1 | One-cycle pulse that zeroes both counters |
| rx_addr_i | input | ADDR_W | Byte address, two cycles ahead of the data |
| rx_we_i | input | 1 | Byte strobe, two cycles ahead of the data |
| rx_byte_i | input | 8 | Received data byte |
| buf_wr_en_o | output | 1 | Packet buffer write enable (normal mode) |
| buf_wr_addr_o | output | ADDR_W | Packet buffer write address |
| buf_wr_data_o | output | 8 | Packet buffer write data |
| gold_rd_en_o | output | 1 | Golden buffer read enable (BER mode) |
| gold_rd_addr_o | output | ADDR_W | Golden buffer read address |
| gold_rd_data_i | input | 8 | Golden byte, one cycle after the read |
| err_bits_o | output | CNT_W | Saturating bit error count |
| tot_bits_o | output | CNT_W | Saturating count of bits checked |

## Verification
The assertions assume that `clear_i` is a single-cycle pulse and that the inputs hold known values during reset. They also assume that the golden port returns data one cycle after each read. The bench keeps to this: it drives only zeros during reset, gives clear pulses one cycle long, and answers reads from a preloaded byte array with one register of latency. The stimulus always places each data byte exactly two cycles after its address and strobe. It changes mode only between packets, so every checked byte has a defined golden partner.

// File: rtl/ber_rt_pkg.sv
package ber_rt_pkg;

  localparam int BYTE_W = 8;
  localparam int POP_W  = 4;

  // number of set bits in a byte, 0..8
  function automatic logic [POP_W-1:0] pop8(input logic [BYTE_W-1:0] v);
    logic [POP_W-1:0] n;
    n = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      n = n + {{(POP_W-1){1'b0}}, v[i]};
    end
    return n;
  endfunction

endpackage

// File: rtl/ber_delay.sv
module ber_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [DEPTH-1:0][W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else begin
      sr[0] <= d;
      for (int i = 1; i < DEPTH; i++) begin
        sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[DEPTH-1];

endmodule

// File: rtl/ber_cmp_stage.sv
module ber_cmp_stage
  import ber_rt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic [BYTE_W-1:0] gold_i,
  output logic              cmp_vld_o,
  output logic [POP_W-1:0]  cmp_err_o
);

  logic [BYTE_W-1:0] rx_hold;

  // hold the received byte for the one-cycle golden read latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_vld_o <= 1'b0;
      rx_hold   <= '0;
    end else begin
      cmp_vld_o <= rd_issue_i;
      rx_hold   <= rx_byte_i;
    end
  end

  assign cmp_err_o = pop8(rx_hold ^ gold_i);

endmodule

// File: rtl/ber_sat_acc.sv
module ber_sat_acc #(
  parameter int CNT_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_en_i,
  input  logic [INC_W-1:0] add_i,
  output logic [CNT_W-1:0] cnt_o
);

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (add_en_i) begin
      cnt_o <= sat_add(cnt_o, add_i);
    end
  end

endmodule

// File: rtl/ber_rt_checker.sv
module ber_rt_checker
  import ber_rt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32,
  parameter int RX_LAG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ber_mode_i,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic              rx_we_i,
  input  logic [7:0]        rx_byte_i,
  output logic              buf_wr_en_o,
  output logic [ADDR_W-1:0] buf_wr_addr_o,
  output logic [7:0]        buf_wr_data_o,
  output logic              gold_rd_en_o,
  output logic [ADDR_W-1:0] gold_rd_addr_o,
  input  logic [7:0]        gold_rd_data_i,
  output logic [CNT_W-1:0]  err_bits_o,
  output logic [CNT_W-1:0]  tot_bits_o
);

  localparam int NUM_ACC = 2;
  localparam int ACC_ERR = 0;
  localparam int ACC_TOT = 1;

  logic [ADDR_W-1:0] al_addr;
  logic              al_we;
  logic              cmp_vld;
  logic [POP_W-1:0]  cmp_err;

  // retime address and strobe to the data byte
  ber_delay #(.W(ADDR_W + 1), .DEPTH(RX_LAG)) u_align (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rx_addr_i, rx_we_i}),
    .q     ({al_addr, al_we})
  );

  assign buf_wr_en_o    = al_we & ~ber_mode_i;
  assign buf_wr_addr_o  = al_addr;
  assign buf_wr_data_o  = rx_byte_i;
  assign gold_rd_en_o   = al_we & ber_mode_i;
  assign gold_rd_addr_o = al_addr;

  ber_cmp_stage u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_issue_i (gold_rd_en_o),
    .rx_byte_i  (rx_byte_i),
    .gold_i     (gold_rd_data_i),
    .cmp_vld_o  (cmp_vld),
    .cmp_err_o  (cmp_err)
  );

  logic [NUM_ACC-1:0][POP_W-1:0] acc_inc;
  logic [NUM_ACC-1:0][CNT_W-1:0] acc_cnt;

  assign acc_inc[ACC_ERR] = cmp_err;
  assign acc_inc[ACC_TOT] = POP_W'(BYTE_W);

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_acc
    ber_sat_acc #(.CNT_W(CNT_W), .INC_W(POP_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (clear_i),
      .add_en_i (cmp_vld),
      .add_i    (acc_inc[k]),
      .cnt_o    (acc_cnt[k])
    );
  end

  assign err_bits_o = acc_cnt[ACC_ERR];
  assign tot_bits_o = acc_cnt[ACC_TOT];

endmodule

// File: rtl/ber_rt_checker_sva.sv
module ber_rt_checker_sva #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ber_mode_i,
  input logic              clear_i,
  input logic              rx_we_i,
  input logic [ADDR_W-1:0] rx_addr_i,
  input logic              buf_wr_en_o,
  input logic              gold_rd_en_o,
  input logic [ADDR_W-1:0] gold_rd_addr_o,
  input logic              cmp_vld,
  input logic [CNT_W-1:0]  err_bits_o,
  input logic [CNT_W-1:0]  tot_bits_o
);

  p_no_write_in_ber_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ber_mode_i |-> !buf_wr_en_o);

  p_wr_strobe_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en_o |-> $past(rx_we_i, 2));

  p_gold_addr_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gold_rd_en_o |-> ($past(rx_we_i, 2) && gold_rd_addr_o == $past(rx_addr_i, 2)));

  p_cmp_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gold_rd_en_o |=> cmp_vld);

  p_err_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_bits_o <= tot_bits_o);

  p_total_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (tot_bits_o == $past(tot_bits_o)) ||
                 (tot_bits_o == $past(tot_bits_o) + CNT_W'(8)) || (&tot_bits_o));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_vld && !clear_i) |=> ($stable(err_bits_o) && $stable(tot_bits_o)));

  p_sat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&err_bits_o) && !clear_i) |=> (&err_bits_o));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (err_bits_o == '0 && tot_bits_o == '0));

endmodule

bind ber_rt_checker ber_rt_checker_sva #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .ber_mode_i     (ber_mode_i),
  .clear_i        (clear_i),
  .rx_we_i        (rx_we_i),
  .rx_addr_i      (rx_addr_i),
  .buf_wr_en_o    (buf_wr_en_o),
  .gold_rd_en_o   (gold_rd_en_o),
  .gold_rd_addr_o (gold_rd_addr_o),
  .cmp_vld        (cmp_vld),
  .err_bits_o     (err_bits_o),
  .tot_bits_o     (tot_bits_o)
);

// File: tb/ber_rt_checker_tb.sv
`timescale 1ns/1ps
module ber_rt_checker_tb;

  localparam int AW    = 16;
  localparam int SAT_W = 6;
  localparam longint SAT_MAX = (64'd1 << SAT_W) - 1;
  localparam longint BIG_MAX = (64'd1 << 32) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          mode_in = 1'b0, clr_in = 1'b0, we_in = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0]    byte_in = '0;

  logic          wen_a, ren_a, wen_b, ren_b;
  logic [AW-1:0] waddr_a, raddr_a, waddr_b, raddr_b;
  logic [7:0]    wdata_a, wdata_b, gq_a, gq_b;
  logic [31:0]   err_a, tot_a;
  logic [SAT_W-1:0] err_b, tot_b;

  logic [7:0] gmem [256];

  always @(posedge clk) begin
    if (ren_a) gq_a <= gmem[raddr_a[7:0]];
    if (ren_b) gq_b <= gmem[raddr_b[7:0]];
  end

  ber_rt_checker u_dut (
    .clk(clk), .rst_n(rst_n), .ber_mode_i(mode_in), .clear_i(clr_in),
    .rx_addr_i(addr_in), .rx_we_i(we_in), .rx_byte_i(byte_in),
    .buf_wr_en_o(wen_a), .buf_wr_addr_o(waddr_a), .buf_wr_data_o(wdata_a),
    .gold_rd_en_o(ren_a), .gold_rd_addr_o(raddr_a), .gold_rd_data_i(gq_a),
    .err_bits_o(err_a), .tot_bits_o(tot_a));

  ber_rt_checker #(.CNT_W(SAT_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .ber_mode_i(mode_in), .clear_i(clr_in),
    .rx_addr_i(addr_in), .rx_we_i(we_in), .rx_byte_i(byte_in),
    .buf_wr_en_o(wen_b), .buf_wr_addr_o(waddr_b), .buf_wr_data_o(wdata_b),
    .gold_rd_en_o(ren_b), .gold_rd_addr_o(raddr_b), .gold_rd_data_i(gq_b),
    .err_bits_o(err_b), .tot_bits_o(tot_b));

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [AW-1:0] h_a [2];
  logic          h_w [2];
  bit     pend_v = 1'b0;
  longint pend_e = 0;
  longint m_err = 0, m_tot = 0, s_err = 0, s_tot = 0;

  function automatic longint clamp_add(longint v, longint inc, longint lim);
    return (v + inc > lim) ? lim : v + inc;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    bit ew;
    bit er;
    ew = h_w[1] && !mode_in;
    er = h_w[1] && mode_in;
    chk(mode_in ? "R1 write suppressed" : "R2 write enable", longint'(wen_a), longint'(ew));
    chk(mode_in ? "R1 write suppressed sat" : "R2 write enable sat", longint'(wen_b), longint'(ew));
    if (ew) begin
      chk("R2 write addr", longint'(waddr_a), longint'(h_a[1]));
      chk("R2 write data", longint'(wdata_a), longint'(byte_in));
    end
    chk("R3 gold read enable", longint'(ren_a), longint'(er));
    if (er) chk("R3 gold read addr", longint'(raddr_a), longint'(h_a[1]));
    chk("R4/R6/R8 error count", longint'(err_a), m_err);
    chk("R5/R6/R8 total count", longint'(tot_a), m_tot);
    chk("R7 error count saturating", longint'(err_b), s_err);
    chk("R7 total count saturating", longint'(tot_b), s_tot);
  endtask

  // one clock cycle: drive at negedge, check 1ns before posedge, advance model
  task automatic step(logic [AW-1:0] a, logic w, logic [7:0] b, logic m, logic c);
    addr_in = a; we_in = w; byte_in = b; mode_in = m; clr_in = c;
    #1;
    check_outputs();
    @(posedge clk);
    if (c) begin
      m_err = 0; m_tot = 0; s_err = 0; s_tot = 0;
    end else if (pend_v) begin
      m_err = clamp_add(m_err, pend_e, BIG_MAX);
      m_tot = clamp_add(m_tot, 8, BIG_MAX);
      s_err = clamp_add(s_err, pend_e, SAT_MAX);
      s_tot = clamp_add(s_tot, 8, SAT_MAX);
    end
    pend_v = h_w[1] && m;
    pend_e = $countones(b ^ gmem[h_a[1][7:0]]);
    h_a[1] = h_a[0]; h_a[0] = a;
    h_w[1] = h_w[0]; h_w[0] = w;
    @(negedge clk);
  endtask

  // packet of n bytes from address base; data of byte j lags its strobe by 2
  task automatic pkt(int base, int n, bit m, int flipmul, bit gap, int clr_at);
    for (int j = 0; j < n + 2; j++) begin
      logic [AW-1:0] a;
      logic w;
      logic [7:0] b;
      a = (j < n) ? AW'(base + j) : '0;
      w = (j < n) && !(gap && (j % 3 == 1));
      b = (j >= 2) ? (gmem[8'(base + j - 2)] ^ 8'((flipmul * (j - 2)) & 255)) : 8'h3C;
      step(a, w, b, m, (j == clr_at));
    end
  endtask

  task automatic idle(int k, bit m);
    for (int i = 0; i < k; i++) step('0, 1'b0, 8'h5A, m, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) gmem[i] = 8'((i * 37 + 5) & 255);
    h_a[0] = '0; h_a[1] = '0; h_w[0] = 1'b0; h_w[1] = 1'b0;
    @(negedge clk);
    // R9: reset state
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R9 reset write enable", longint'(wen_a), 0);
      chk("R9 reset read enable", longint'(ren_a), 0);
      chk("R9 reset error count", longint'(err_a), 0);
      chk("R9 reset total count", longint'(tot_a), 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    idle(3, 1'b0);
    // R2/R6: normal mode writes, counters hold
    pkt(0, 16, 1'b0, 0, 1'b0, -1);
    idle(3, 1'b0);
    // R3/R4/R5: BER mode, clean packet from address 0
    pkt(0, 20, 1'b1, 0, 1'b0, -1);
    idle(3, 1'b1);
    // R4: bit flips in a varying pattern, gapped strobe
    pkt(0, 24, 1'b1, 29, 1'b1, -1);
    idle(3, 1'b1);
    pkt(100, 12, 1'b1, 255, 1'b0, -1);
    idle(3, 1'b1);
    // R6: normal mode with corrupted data must not count
    pkt(40, 10, 1'b0, 7, 1'b0, -1);
    idle(3, 1'b0);
    // R8: clear in the middle of a BER packet, then alone
    pkt(10, 12, 1'b1, 3, 1'b0, 6);
    idle(2, 1'b1);
    step('0, 1'b0, 8'h00, 1'b1, 1'b1);
    idle(2, 1'b1);
    // R7: long dirty packet drives the narrow instance into saturation
    pkt(0, 40, 1'b1, 255, 1'b0, -1);
    idle(3, 1'b1);
    step('0, 1'b0, 8'h00, 1'b1, 1'b1);
    pkt(200, 30, 1'b1, 85, 1'b1, -1);
    idle(4, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule